// File: doc/BRIEF.md
# Line-Locked Horizontal/Vertical Reset with Field Selection

This block lets several cameras that share one pixel clock restart their horizontal and vertical timing chains together. Two active-low strobes arrive from outside. Each strobe passes through a two-stage synchronizer. A qualified low on the horizontal strobe restarts the line. The block issues a load pulse and a start value for the horizontal counter, and it also restarts its own copy of the position within the line.

A falling edge on the vertical strobe is judged by where it lands within the current line. A leading window selects the odd field. A middle window selects the even field. In normal mode, a trailing window selects odd again. A narrow guard band sits on each window boundary. An edge inside a guard band keeps the previous field and sets a sticky warning. Once the field is chosen, the block pulses a vertical load with a line number. That number makes vertical drive begin nine lines later, at the start of the chosen field.

A mode input selects direct reset. In that mode the line position does not wrap at the nominal line length, so the horizontal strobe may arrive at any period. The trailing odd window and its guard band are dropped, so every edge past the first boundary selects even.

Top module: `hv_lock_reset`

## Requirements
- R1: While reset is applied, h_load and v_load are 0, field_odd is 1 and guard_warn is 0.
- R2: A low on hreset_n that lasts at least MIN_HLOW (4) clocks produces exactly one h_load pulse. The pulse is visible after the sixth rising edge following the edge at which the low was first presented. h_load_val is 5. A low of 3 clocks or fewer produces no pulse and leaves the line position unchanged.
- R3: A falling edge on vreset_n produces a single-cycle v_load. The pulse is visible after the third rising edge following the edge at which the low was first presented.
- R4: In normal mode the line position is 5 on the cycle after h_load and wraps from 779 to 0. A vertical edge judged at position p selects odd for p < 269, even for 269 ≤ p < 657, and odd for p ≥ 657. The vertical edge is judged two clocks after its low is presented.
- R5: Positions 266 to 271 and 654 to 659 are guard bands. An edge there keeps field_odd unchanged, still pulses v_load, and sets guard_warn, which stays 1 until reset.
- R6: In direct mode the line position does not wrap and saturates at 2047. p < 269 selects odd and p ≥ 269 selects even, and only positions 266 to 271 are a guard band.
- R7: With v_load, v_load_val is 516 when the field is odd and 254 when it is even. These are the lines nine before the odd field start (line 0) and the even field start (line 263) in a 525-line frame.
- R8: When a horizontal restart and a vertical edge fall on the same cycle, the vertical edge is judged at the position before the restart, and h_load and v_load are visible together.
- R9: A rising edge on vreset_n or hreset_n produces no v_load and no h_load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hreset_n | input | 1 | External horizontal restart strobe, active low, asynchronous |
| vreset_n | input | 1 | External vertical restart strobe, active low, asynchronous |
| direct_mode | input | 1 | 1 selects direct reset (no line wrap, no trailing odd window) |
| h_load | output | 1 | One-cycle load command for the horizontal counter |
| h_load_val | output | 11 | Value loaded into the horizontal counter |
| v_load | output | 1 | One-cycle load command for the vertical counter |
| v_load_val | output | 10 | Line number loaded into the vertical counter |
| field_odd | output | 1 | Selected field, 1 for odd |
| guard_warn | output | 1 | Sticky flag: a vertical edge fell in a guard band |

## Verification
The horizontal restart and the vertical edge judgement can both happen in the same clock. In that case the position used for the judgement may be either the old line position or the freshly loaded one. The bench provokes this by dropping the vertical strobe exactly three clocks after the horizontal strobe, so that the qualified horizontal low and the synchronized vertical edge meet. It places the old position in the even window while the previous field is already even, so using the reloaded position would wrongly yield odd. It then requires h_load and v_load in the same sample, with the even field and its load value.

// File: rtl/hvl_pkg.sv
package hvl_pkg;
  typedef enum logic [1:0] {
    WIN_ODD   = 2'd0,
    WIN_EVEN  = 2'd1,
    WIN_GUARD = 2'd2
  } win_e;
endpackage

// File: rtl/hvl_sync_fall.sv
module hvl_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~level;
endmodule

// File: rtl/hvl_width_qual.sv
module hvl_width_qual #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fire
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_LOW);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    if (level)               cnt_n = '0;
    else if (cnt == CNT_SAT) cnt_n = cnt;
    else                     cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign fire = ~level & (cnt == CNT_LAST);
endmodule

// File: rtl/hvl_line_phase.sv
module hvl_line_phase #(
  parameter int LINE  = 780,
  parameter int PW    = 11,
  parameter int START = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          direct,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] P_START = PW'(START);
  localparam logic [PW-1:0] P_LAST  = PW'(LINE - 1);
  localparam logic [PW-1:0] P_MAX   = '1;

  logic [PW-1:0] phase_n;

  always_comb begin
    if (load)                 phase_n = P_START;
    else if (direct)          phase_n = (phase == P_MAX) ? phase : phase + 1'b1;
    else if (phase >= P_LAST) phase_n = '0;
    else                      phase_n = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_n;
  end
endmodule

// File: rtl/hvl_field_sel.sv
module hvl_field_sel
  import hvl_pkg::*;
#(
  parameter int PW        = 11,
  parameter int VW        = 10,
  parameter int BOUND1    = 269,
  parameter int BOUND2    = 657,
  parameter int GUARD     = 3,
  parameter int ODD_LOAD  = 516,
  parameter int EVEN_LOAD = 254
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vfall,
  input  logic          direct,
  input  logic [PW-1:0] phase,
  output logic          v_load,
  output logic [VW-1:0] v_load_val,
  output logic          field_odd,
  output logic          guard_warn
);
  localparam logic [PW-1:0] B1    = PW'(BOUND1);
  localparam logic [PW-1:0] B2    = PW'(BOUND2);
  localparam logic [PW-1:0] B1_LO = PW'(BOUND1 - GUARD);
  localparam logic [PW-1:0] B1_HI = PW'(BOUND1 + GUARD);
  localparam logic [PW-1:0] B2_LO = PW'(BOUND2 - GUARD);
  localparam logic [PW-1:0] B2_HI = PW'(BOUND2 + GUARD);
  localparam logic [VW-1:0] V_ODD  = VW'(ODD_LOAD);
  localparam logic [VW-1:0] V_EVEN = VW'(EVEN_LOAD);

  win_e          win;
  logic          band1, band2;
  logic          v_load_n, field_n, warn_n;
  logic [VW-1:0] val_n;

  assign band1 = (phase >= B1_LO) && (phase < B1_HI);
  assign band2 = (phase >= B2_LO) && (phase < B2_HI);

  always_comb begin
    if (direct) begin
      if (band1)           win = WIN_GUARD;
      else if (phase < B1) win = WIN_ODD;
      else                 win = WIN_EVEN;
    end else begin
      if (band1 || band2)  win = WIN_GUARD;
      else if (phase < B1) win = WIN_ODD;
      else if (phase < B2) win = WIN_EVEN;
      else                 win = WIN_ODD;
    end
  end

  always_comb begin
    v_load_n = vfall;
    field_n  = field_odd;
    warn_n   = guard_warn;
    val_n    = v_load_val;
    if (vfall) begin
      if (win == WIN_GUARD) warn_n  = 1'b1;
      else                  field_n = (win == WIN_ODD);
      val_n = field_n ? V_ODD : V_EVEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_load     <= 1'b0;
      field_odd  <= 1'b1;
      guard_warn <= 1'b0;
      v_load_val <= V_ODD;
    end else begin
      v_load     <= v_load_n;
      field_odd  <= field_n;
      guard_warn <= warn_n;
      v_load_val <= val_n;
    end
  end
endmodule

// File: rtl/hv_lock_reset.sv
module hv_lock_reset #(
  parameter int LINE_CLKS     = 780,
  parameter int ODD_WIN_CLKS  = 269,
  parameter int EVEN_WIN_CLKS = 388,
  parameter int GUARD_CLKS    = 3,
  parameter int MIN_HLOW      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int FRAME_LINES   = 525,
  parameter int VD_DELAY      = 9,
  parameter int PW            = $clog2(LINE_CLKS) + 1,
  parameter int VW            = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hreset_n,
  input  logic          vreset_n,
  input  logic          direct_mode,
  output logic          h_load,
  output logic [PW-1:0] h_load_val,
  output logic          v_load,
  output logic [VW-1:0] v_load_val,
  output logic          field_odd,
  output logic          guard_warn
);
  localparam int H_START   = SYNC_STAGES + MIN_HLOW - 1;
  localparam int BOUND2    = ODD_WIN_CLKS + EVEN_WIN_CLKS;
  localparam int EVEN_LINE = (FRAME_LINES + 1) / 2;
  localparam int ODD_LOAD  = FRAME_LINES - VD_DELAY;
  localparam int EVEN_LOAD = EVEN_LINE - VD_DELAY;

  logic [1:0]    rst_pipe;
  logic          rst_s_n;
  logic          h_level, h_fall_unused, v_level_unused, v_fall, h_fire;
  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  hvl_sync_fall #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk(clk), .rst_n(rst_s_n), .din(hreset_n),
    .level(h_level), .fall(h_fall_unused));

  hvl_sync_fall #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst_n(rst_s_n), .din(vreset_n),
    .level(v_level_unused), .fall(v_fall));

  hvl_width_qual #(.MIN_LOW(MIN_HLOW)) u_hqual (
    .clk(clk), .rst_n(rst_s_n), .level(h_level), .fire(h_fire));

  hvl_line_phase #(.LINE(LINE_CLKS), .PW(PW), .START(H_START)) u_phase (
    .clk(clk), .rst_n(rst_s_n), .load(h_fire), .direct(direct_mode),
    .phase(phase));

  hvl_field_sel #(
    .PW(PW), .VW(VW), .BOUND1(ODD_WIN_CLKS), .BOUND2(BOUND2),
    .GUARD(GUARD_CLKS), .ODD_LOAD(ODD_LOAD), .EVEN_LOAD(EVEN_LOAD)
  ) u_field (
    .clk(clk), .rst_n(rst_s_n), .vfall(v_fall), .direct(direct_mode),
    .phase(phase), .v_load(v_load), .v_load_val(v_load_val),
    .field_odd(field_odd), .guard_warn(guard_warn));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) h_load <= 1'b0;
    else          h_load <= h_fire;
  end

  assign h_load_val = PW'(H_START);
endmodule

// File: rtl/hvl_checker.sv
module hvl_checker #(
  parameter int VW          = 10,
  parameter int FRAME_LINES = 525,
  parameter int VD_DELAY    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_load,
  input logic          v_load,
  input logic [VW-1:0] v_load_val,
  input logic          field_odd,
  input logic          guard_warn
);
  localparam logic [VW-1:0] V_ODD  = VW'(FRAME_LINES - VD_DELAY);
  localparam logic [VW-1:0] V_EVEN = VW'((FRAME_LINES + 1) / 2 - VD_DELAY);

  a_r2_hload_single: assert property (@(posedge clk) disable iff (!rst_n)
    h_load |=> !h_load);

  a_r3_vload_single: assert property (@(posedge clk) disable iff (!rst_n)
    v_load |=> !v_load);

  a_r5_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    guard_warn |=> guard_warn);

  a_r5_field_moves_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    (field_odd != $past(field_odd)) |-> v_load);

  a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    v_load |-> (v_load_val == (field_odd ? V_ODD : V_EVEN)));
endmodule

bind hv_lock_reset hvl_checker #(
  .VW(VW), .FRAME_LINES(FRAME_LINES), .VD_DELAY(VD_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_load(h_load), .v_load(v_load),
  .v_load_val(v_load_val), .field_odd(field_odd), .guard_warn(guard_warn));

// File: tb/sim_hv_lock_reset.sv
module sim_hv_lock_reset;
  localparam int LINE  = 780;
  localparam int B1    = 269;
  localparam int B2    = 657;
  localparam int G     = 3;
  localparam int HST   = 5;
  localparam int VLAT  = 3;
  localparam int ODDV  = 516;
  localparam int EVENV = 254;
  localparam int PMAX  = 2047;

  logic        clk = 1'b0;
  logic        rst_n, hr_n, vr_n, dmode;
  logic        h_load, v_load, f_odd, warn;
  logic [10:0] h_val;
  logic [9:0]  v_val;
  int checks = 0, errors = 0, cyc = 0;
  bit exp_odd = 1'b1, exp_warn = 1'b0;

  always #4 clk = ~clk;

  hv_lock_reset u0 (
    .clk(clk), .rst_n(rst_n), .hreset_n(hr_n), .vreset_n(vr_n),
    .direct_mode(dmode), .h_load(h_load), .h_load_val(h_val),
    .v_load(v_load), .v_load_val(v_val), .field_odd(f_odd),
    .guard_warn(warn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pos_of(input bit d, input int j);
    int p = HST + 2 + j;
    if (!d) p = p % LINE;
    else if (p > PMAX) p = PMAX;
    return p;
  endfunction

  function automatic int j_for(input bit d, input int p);
    if (d || p >= HST + 2) return p - HST - 2;
    return p + LINE - HST - 2;
  endfunction

  // 0 odd, 1 even, 2 guard
  function automatic int cls(input bit d, input int p);
    if (p >= B1 - G && p < B1 + G) return 2;
    if (!d && p >= B2 - G && p < B2 + G) return 2;
    if (p < B1) return 0;
    if (d || p < B2) return 1;
    return 0;
  endfunction

  function automatic void apply(input int c);
    if (c == 2) exp_warn = 1'b1;
    else        exp_odd  = (c == 0);
  endfunction

  task automatic hpulse(output int lat);
    hr_n = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!h_load && lat < 40);
    hr_n = 1'b1;
  endtask

  task automatic check_vload(input string req);
    chk(v_load == 1'b1, "R3", int'(v_load), 1);
    chk(f_odd == exp_odd, req, int'(f_odd), int'(exp_odd));
    chk(v_val == (exp_odd ? ODDV : EVENV), "R7", int'(v_val), exp_odd ? ODDV : EVENV);
    chk(warn == exp_warn, "R5", int'(warn), int'(exp_warn));
  endtask

  task automatic trial(input bit d, input int j, input string req);
    int lat;
    bit seen;
    @(negedge clk) dmode = d;
    hpulse(lat);
    chk(lat == 6 && h_val == 11'(HST), "R2", lat, 6);
    repeat (j) @(negedge clk);
    vr_n = 1'b0;
    apply(cls(d, pos_of(d, j)));
    repeat (VLAT) @(negedge clk);
    check_vload(req);
    vr_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (v_load || h_load) seen = 1'b1;
    end
    chk(!seen, "R9", int'(seen), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    bit seen;
    rst_n = 1'b0; hr_n = 1'b1; vr_n = 1'b1; dmode = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(h_load == 0 && v_load == 0, "R1", int'(h_load) + int'(v_load), 0);
    chk(f_odd == 1 && warn == 0, "R1", int'(f_odd), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R4 normal windows, including wrap
    trial(0, j_for(0, 10),  "R4");
    trial(0, j_for(0, 265), "R4");
    trial(0, j_for(0, 272), "R4");
    trial(0, j_for(0, 653), "R4");
    trial(0, j_for(0, 660), "R4");
    trial(0, j_for(0, 400), "R4");
    trial(0, j_for(0, 779), "R4");
    trial(0, j_for(0, 3),   "R4");

    // R2 short low ignored: position must keep counting from last restart
    @(negedge clk) dmode = 1'b0;
    hpulse(lat);
    seen = 1'b0;
    for (int k = 0; k < 260; k++) @(negedge clk);
    hr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); if (h_load) seen = 1'b1; end
    hr_n = 1'b1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (h_load) seen = 1'b1; end
    chk(!seen, "R2", int'(seen), 0);
    vr_n = 1'b0;
    apply(cls(0, pos_of(0, 273)));
    repeat (VLAT) @(negedge clk);
    check_vload("R2");
    vr_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 coincident restart and vertical edge; previous field is even
    hpulse(lat);
    repeat (390) @(negedge clk);
    hr_n = 1'b0;
    repeat (3) @(negedge clk);
    vr_n = 1'b0;
    apply(cls(0, 400));
    repeat (VLAT) @(negedge clk);
    chk(h_load == 1'b1, "R8", int'(h_load), 1);
    chk(f_odd == exp_odd && v_load, "R8", int'(f_odd), int'(exp_odd));
    hr_n = 1'b1; vr_n = 1'b1;
    repeat (6) @(negedge clk);

    // R5 guard bands (normal)
    trial(0, j_for(0, 266), "R5");
    trial(0, j_for(0, 10),  "R4");
    trial(0, j_for(0, 271), "R5");
    trial(0, j_for(0, 300), "R4");
    trial(0, j_for(0, 654), "R5");
    trial(0, j_for(0, 659), "R5");

    // R6 direct mode
    trial(1, j_for(1, 100),  "R6");
    trial(1, j_for(1, 700),  "R6");
    trial(1, j_for(1, 100),  "R6");
    trial(1, j_for(1, 657),  "R6");
    trial(1, j_for(1, 900),  "R6");
    trial(1, j_for(1, 268),  "R6");
    trial(1, 2100,           "R6");

    // randomized sweep
    void'($urandom(32'd4242));
    for (int t = 0; t < 45; t++) begin
      bit d;
      int j;
      d = 1'($urandom_range(0, 1));
      j = d ? int'($urandom_range(0, 1100)) : int'($urandom_range(0, 779));
      trial(d, j, d ? "R6" : "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule